// File: doc/BRIEF.md
# Threshold-Triggered Disk Data FIFO

This block is the byte queue between the host bus and the serial disk-side controller core. Command parameter bytes and disk data bytes share it and flow in either direction. When the host writes toward the drive, the host fills the queue and the disk side empties it. When data flows toward the host, the disk side fills it and the host empties it. The host sees two handshake bits. `rqm` means the queue can take a host access now. `dio` gives the current direction, where 1 means toward the host. A separate service request `svc_req` tells the host or DMA engine that the fill level has reached the programmed threshold.

After reset the queue runs in a compatibility mode where it holds only one byte, so it acts like a plain holding register. A configure strobe turns on the full 16-byte depth and loads a 4-bit threshold. The threshold sets how much latency the host may take before it must service the queue: the threshold times the time of one byte, less a small fixed margin. A command-start strobe sets the direction, flushes the queue and clears two sticky error flags. Those flags record a disk push into a full queue and a disk pop from an empty queue.

Top module: `disk_byte_fifo`

## Requirements
- R1: After reset the queue is empty and in single-byte mode (`fifo_on`=0). The direction is toward the drive (`dio`=0), `rqm`=1, `svc_req`=1, and both error flags are 0.
- R2: With the queue enabled it stores up to 16 bytes and returns them in the order written. While the host fills it (`dio`=0), `rqm` drops when 16 bytes are held and any further host write is dropped.
- R3: In single-byte mode the queue holds at most one byte. Toward the drive, `rqm` falls once a byte is held and rises again when the disk side takes it. Toward the host, `rqm` rises when a byte is held.
- R4: A `cmd_start` pulse loads `dio` from `cmd_dir`, empties the queue and clears both error flags by the next cycle.
- R5: Toward the host with the queue enabled, `svc_req` is 1 exactly when the level is at least 16 minus the effective threshold.
- R6: Toward the drive with the queue enabled, `svc_req` is 1 exactly when the level is at most the effective threshold.
- R7: A threshold value of 0 behaves as a threshold of 1.
- R8: A disk push while data flows toward the host and the queue is full sets `overrun`. The byte is discarded, and the flag stays set until the next `cmd_start`.
- R9: A disk pop while data flows toward the drive and the queue is empty sets `underrun`, and the flag stays set until the next `cmd_start`.
- R10: A `cfg_wr` pulse takes effect only when the queue is empty. While any byte is held, the pulse leaves the enable and the threshold unchanged.
- R11: Strobes from the wrong side are ignored. These are a host write or a disk pop while data flows toward the host, and a host read or a disk push while data flows toward the drive. They change neither the level nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start of command: load direction, flush, clear flags |
| cmd_dir | input | 1 | Direction for the new command, 1 = toward host |
| cfg_wr | input | 1 | Configure strobe |
| cfg_en | input | 1 | Configure value: 1 enables full depth |
| cfg_thr | input | 4 | Configure value: service threshold |
| host_wr | input | 1 | Host writes a byte |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host takes the head byte |
| disk_wr | input | 1 | Disk side pushes a byte |
| disk_wdata | input | 8 | Disk push byte |
| disk_rd | input | 1 | Disk side takes the head byte |
| rd_byte | output | 8 | Head byte of the queue (show-ahead) |
| level | output | 5 | Bytes held |
| rqm | output | 1 | Host may access the queue now |
| dio | output | 1 | Direction, 1 = toward host |
| svc_req | output | 1 | Threshold service request |
| overrun | output | 1 | Sticky disk push into full queue |
| underrun | output | 1 | Sticky disk pop from empty queue |
| fifo_on | output | 1 | Full-depth mode active |

## Verification
The bench checks `svc_req` at every fill level around the threshold in both directions, including thresholds 0, 2, 8 and 15. A design with an off-by-one in the comparison would raise the request one byte early or late, and one that does not map 0 to 1 would wait until the queue is full. It checks that the single-byte mode really caps the queue at one byte. If it did not, `rqm` would stay high after the first host write and a second disk push would not raise `overrun`. It sends a configure strobe while a byte is held and then watches `fifo_on` and the threshold behaviour. It also sends strobes from the wrong side and checks the level and the flags, which catches designs that take pushes from either side or raise an error on an ignored pop.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
    localparam int BYTE_W = 8;
    localparam int THR_W  = 4;

    typedef enum logic {
        DIR_TO_DEV  = 1'b0,
        DIR_TO_HOST = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] thr;
    } fifo_cfg_t;

    localparam fifo_cfg_t CFG_RESET = '{en: 1'b0, thr: THR_W'(1)};

    // a zero threshold is promoted to one
    function automatic int eff_thr(input logic [THR_W-1:0] t);
        return (t == '0) ? 1 : int'(t);
    endfunction
endpackage

// File: rtl/dfq_store.sv
module dfq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rp];

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/dfq_ctrl.sv
module dfq_ctrl
    import dfq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_start,
    input  logic      cmd_dir,
    input  logic      cfg_wr,
    input  fifo_cfg_t cfg_in,
    input  logic      empty,
    input  logic      ovr_evt,
    input  logic      und_evt,
    output xfer_dir_e dir,
    output fifo_cfg_t cfg,
    output logic      ovr,
    output logic      und
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= DIR_TO_DEV;
            cfg <= CFG_RESET;
            ovr <= 1'b0;
            und <= 1'b0;
        end else begin
            if (cmd_start) begin
                dir <= xfer_dir_e'(cmd_dir);
                ovr <= 1'b0;
                und <= 1'b0;
            end else begin
                if (ovr_evt) ovr <= 1'b1;
                if (und_evt) und <= 1'b1;
            end
            if (cfg_wr && empty) cfg <= cfg_in;
        end
    end

    assert_cfg_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !empty) |=> $stable(cfg));
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr && !cmd_start) |=> ovr);
    assert_und_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (und && !cmd_start) |=> und);
endmodule

// File: rtl/dfq_handshake.sv
module dfq_handshake
    import dfq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  xfer_dir_e        dir,
    input  fifo_cfg_t        cfg,
    input  logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             rqm,
    output logic             svc
);
    int cap, lvl, thr;

    always_comb begin
        cap   = cfg.en ? DEPTH : 1;
        lvl   = int'(count);
        thr   = eff_thr(cfg.thr);
        full  = (lvl >= cap);
        empty = (lvl == 0);
        rqm   = (dir == DIR_TO_HOST) ? !empty : !full;
        if (cfg.en)
            svc = (dir == DIR_TO_HOST) ? (lvl + thr >= DEPTH) : (lvl <= thr);
        else
            svc = (dir == DIR_TO_HOST) ? !empty : empty;
    end
endmodule

// File: rtl/disk_byte_fifo.sv
module disk_byte_fifo
    import dfq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_dir,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              disk_wr,
    input  logic [BYTE_W-1:0] disk_wdata,
    input  logic              disk_rd,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CNT_W-1:0]  level,
    output logic              rqm,
    output logic              dio,
    output logic              svc_req,
    output logic              overrun,
    output logic              underrun,
    output logic              fifo_on
);
    xfer_dir_e         dir;
    fifo_cfg_t         cfg, cfg_in;
    logic              full, empty, to_host;
    logic              push_req, pop_req, push_ok, pop_ok;
    logic              ovr_evt, und_evt;
    logic [BYTE_W-1:0] wdata;

    assign cfg_in   = '{en: cfg_en, thr: cfg_thr};
    assign to_host  = (dir == DIR_TO_HOST);
    assign push_req = to_host ? disk_wr : host_wr;
    assign pop_req  = to_host ? host_rd : disk_rd;
    assign wdata    = to_host ? disk_wdata : host_wdata;
    assign push_ok  = push_req && !full && !cmd_start;
    assign pop_ok   = pop_req && !empty && !cmd_start;
    assign ovr_evt  = to_host && disk_wr && full;
    assign und_evt  = !to_host && disk_rd && empty;

    dfq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk(clk), .rst(rst), .flush(cmd_start),
        .push(push_ok), .pop(pop_ok), .wdata(wdata),
        .rdata(rd_byte), .count(level)
    );

    dfq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_dir(cmd_dir),
        .cfg_wr(cfg_wr), .cfg_in(cfg_in), .empty(empty),
        .ovr_evt(ovr_evt), .und_evt(und_evt),
        .dir(dir), .cfg(cfg), .ovr(overrun), .und(underrun)
    );

    dfq_handshake #(.DEPTH(DEPTH)) u_hs (
        .dir(dir), .cfg(cfg), .count(level),
        .full(full), .empty(empty), .rqm(rqm), .svc(svc_req)
    );

    assign dio     = to_host;
    assign fifo_on = cfg.en;

    assert_single_byte_R3: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |-> (level <= CNT_W'(1)));
    assert_flush_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (level == '0 && !overrun && !underrun && dio == $past(cmd_dir)));
    assert_full_reject_R2: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !pop_req && !cmd_start) |=> $stable(level));
endmodule

// File: tb/tb_disk_byte_fifo.sv
module tb_disk_byte_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_start = 0, cmd_dir = 0, cfg_wr = 0, cfg_en = 0;
    logic [3:0] cfg_thr = 0;
    logic       host_wr = 0, host_rd = 0, disk_wr = 0, disk_rd = 0;
    logic [7:0] host_wdata = 0, disk_wdata = 0;
    logic [7:0] rd_byte;
    logic [4:0] level;
    logic       rqm, dio, svc_req, overrun, underrun, fifo_on;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    disk_byte_fifo dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_dir(cmd_dir),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_thr(cfg_thr),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .disk_wr(disk_wr), .disk_wdata(disk_wdata), .disk_rd(disk_rd),
        .rd_byte(rd_byte), .level(level), .rqm(rqm), .dio(dio),
        .svc_req(svc_req), .overrun(overrun), .underrun(underrun), .fifo_on(fifo_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        cmd_start = 0; cfg_wr = 0; host_wr = 0; host_rd = 0; disk_wr = 0; disk_rd = 0;
    endtask

    task automatic start_cmd(input logic d);
        cmd_start = 1; cmd_dir = d; step();
    endtask
    task automatic configure(input logic en, input logic [3:0] t);
        cfg_wr = 1; cfg_en = en; cfg_thr = t; step();
    endtask
    task automatic hwr(input logic [7:0] b); host_wr = 1; host_wdata = b; step(); endtask
    task automatic dwr(input logic [7:0] b); disk_wr = 1; disk_wdata = b; step(); endtask
    task automatic hrd(); host_rd = 1; step(); endtask
    task automatic drd(); disk_rd = 1; step(); endtask

    task automatic t_reset();
        chk("R1 level", int'(level), 0);
        chk("R1 fifo_on", int'(fifo_on), 0);
        chk("R1 dio", int'(dio), 0);
        chk("R1 rqm", int'(rqm), 1);
        chk("R1 svc", int'(svc_req), 1);
        chk("R1 flags", int'({overrun, underrun}), 0);
    endtask

    task automatic t_single_write();
        hwr(8'hA5);
        chk("R3 level after one", int'(level), 1);
        chk("R3 rqm low when held", int'(rqm), 0);
        hwr(8'h11);
        chk("R3 second write dropped", int'(level), 1);
        chk("R3 held byte", int'(rd_byte), 8'hA5);
        drd();
        chk("R3 rqm back", int'(rqm), 1);
        chk("R3 level empty", int'(level), 0);
    endtask

    task automatic t_single_read();
        start_cmd(1);
        chk("R4 dio", int'(dio), 1);
        chk("R3 rqm empty to host", int'(rqm), 0);
        dwr(8'h3C);
        chk("R3 rqm with byte", int'(rqm), 1);
        chk("R3 svc with byte", int'(svc_req), 1);
        dwr(8'h44);
        chk("R8 overrun on full", int'(overrun), 1);
        chk("R8 byte discarded", int'(level), 1);
        chk("R8 head kept", int'(rd_byte), 8'h3C);
        hrd();
        chk("R8 sticky", int'(overrun), 1);
        start_cmd(0);
        chk("R4 clears overrun", int'(overrun), 0);
        chk("R4 dio back", int'(dio), 0);
    endtask

    task automatic t_full_write();
        configure(1, 4'd8);
        chk("R10 cfg when empty", int'(fifo_on), 1);
        for (int i = 0; i < 16; i++) begin
            hwr(8'(i * 7 + 1));
            chk("R6 svc thr8", int'(svc_req), int'((i + 1) <= 8));
        end
        chk("R2 level 16", int'(level), 16);
        chk("R2 rqm full", int'(rqm), 0);
        hwr(8'hEE);
        chk("R2 overflow write dropped", int'(level), 16);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order", int'(rd_byte), int'(8'(i * 7 + 1)));
            drd();
        end
        chk("R9 no underrun yet", int'(underrun), 0);
        drd();
        chk("R9 underrun", int'(underrun), 1);
        step();
        chk("R9 sticky", int'(underrun), 1);
    endtask

    task automatic t_busy_cfg();
        hwr(8'h01);
        configure(0, 4'd2);
        chk("R10 enable kept", int'(fifo_on), 1);
        hwr(8'h02);
        hwr(8'h03);
        chk("R10 threshold kept", int'(svc_req), 1);
    endtask

    task automatic t_read_thresh();
        start_cmd(1);
        chk("R4 flush", int'(level), 0);
        chk("R4 clears underrun", int'(underrun), 0);
        configure(1, 4'd2);
        for (int i = 0; i < 14; i++) begin
            dwr(8'(i + 8'h40));
            chk("R5 svc thr2", int'(svc_req), int'((i + 1) >= 14));
        end
        hwr(8'h99);
        chk("R11 host write ignored", int'(level), 14);
        drd();
        chk("R11 disk pop ignored", int'(level), 14);
        chk("R11 no underrun", int'(underrun), 0);
        for (int i = 0; i < 14; i++) begin
            chk("R2 order to host", int'(rd_byte), i + 8'h40);
            hrd();
        end
        chk("R5 svc drained", int'(svc_req), 0);
    endtask

    task automatic t_thr_edges();
        start_cmd(1);
        configure(1, 4'd0);
        for (int i = 0; i < 15; i++) begin
            dwr(8'(i));
            chk("R7 svc zero thr read", int'(svc_req), int'((i + 1) >= 15));
        end
        start_cmd(0);
        chk("R7 svc empty write", int'(svc_req), 1);
        hwr(8'h10);
        chk("R7 svc level1", int'(svc_req), 1);
        hwr(8'h20);
        chk("R7 svc level2", int'(svc_req), 0);
        start_cmd(0);
        configure(1, 4'd15);
        for (int i = 0; i < 16; i++) begin
            hwr(8'(i));
            chk("R6 svc thr15", int'(svc_req), int'((i + 1) <= 15));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_single_write();
        t_single_read();
        t_full_write();
        t_busy_cfg();
        t_read_thresh();
        t_thr_edges();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule